// File: doc/BRIEF.md
# Power-on Reset Pulse Stretcher

This block produces the system reset after power-up and after a front-panel reset request. A single digital line stands for the combined power-good and reset-switch signal. While the line is low, which happens during power-up or while the switch is held, the block keeps reset asserted. When the line goes high again, a down-counter holds reset for a fixed number of clock cycles and then releases it.

The timer is retriggerable. If the line drops low at any point during an active pulse, even for a single cycle, the count reloads. The full width then starts again from the last low-to-high transition. The line is asynchronous to the clock, so it passes through a synchronizer chain before the timer uses it.

Both an active-high and an active-low reset are provided, each from its own register. Every register has a power-up value, so reset is asserted from the first instant of operation without any external reset input. The default pulse length is 3500 cycles, which is 70 microseconds at 50 MHz.

Top module: `rsg_por_stretch`

## Requirements
- R1: From time zero, before any clock edge, `rst_o` is 1 and `rst_n_o` is 0. They keep these values until a release occurs as described in R4.
- R2: On every cycle, `rst_n_o` is the logical complement of `rst_o`.
- R3: If `pwr_ok_i` is sampled low at rising edge n, then `rst_o` is 1 after edge n+SYNC_STAGES. It stays 1 for as long as later edges keep sampling the line low.
- R4: Let n be the last rising edge that sampled `pwr_ok_i` low, with the line high at every edge after it. Then `rst_o` stays 1 through edge n+SYNC_STAGES+PULSE_CYCLES and becomes 0 after edge n+SYNC_STAGES+PULSE_CYCLES+1. At power-up, the line counts as low at every edge before the first one.
- R5: A low sample of any length, including one cycle, that arrives while the pulse is still running reloads the full width. Release then follows R4, measured from that new low sample.
- R6: Once `rst_o` has fallen, it stays 0 for as long as `pwr_ok_i` stays high.
- R7: After a release, a new low period on `pwr_ok_i` (a switch press) asserts reset again, and reset repeats the full pulse width after the line returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running clock |
| pwr_ok_i | input | 1 | Asynchronous power-good / reset-switch line; low requests reset |
| rst_o | output | 1 | Registered active-high system reset |
| rst_n_o | output | 1 | Registered active-low system reset |

## Verification
Two events can fall in the same cycle: the counter reaching its expiry and a fresh low sample that must reload it. When they coincide, the reload must win, so reset never drops for even one cycle.

The bench provokes this with a sweep. After each release it waits every possible offset, from zero cycles up to one cycle past the nominal expiry, before applying a short low pulse of one to three cycles. This places the retrigger before, on, and after the expiry cycle.

Expected reset values come from a bench-side history of the line. Reset is expected high whenever any sample inside the window from SYNC_STAGES to SYNC_STAGES+PULSE_CYCLES edges ago was low. This window rule judges both outputs on every cycle, so an early drop or a one-cycle late release is reported as a mismatch.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

  // Counter width able to hold the value n (at least one bit).
  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // 70 us at a 50 MHz clock.
  localparam int unsigned RSG_DEFAULT_PULSE = 3500;
  localparam int unsigned RSG_DEFAULT_SYNC  = 2;

endpackage

// File: rtl/rsg_sync.sv
module rsg_sync #(
  parameter int unsigned STAGES = rsg_pkg::RSG_DEFAULT_SYNC
) (
  input  logic clk_i,
  input  logic d_i,
  output logic q_o
);

  // Power-up value 0: the line is treated as low until sampled high.
  logic [STAGES-1:0] chain = '0;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i) chain[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i) chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/rsg_timer.sv
module rsg_timer #(
  parameter int unsigned PULSE_CYCLES = rsg_pkg::RSG_DEFAULT_PULSE
) (
  input  logic clk_i,
  input  logic line_i,
  output logic rst_o,
  output logic rst_n_o
);

  localparam int unsigned W    = rsg_pkg::cnt_bits(PULSE_CYCLES);
  localparam logic [W-1:0] FULL = W'(PULSE_CYCLES);
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] cnt    = FULL;
  logic         rst_q  = 1'b1;
  logic         rstn_q = 1'b0;
  logic         warm   = 1'b0;

  always_ff @(posedge clk_i) begin
    warm <= 1'b1;
    if (!line_i) begin
      cnt <= FULL;
    end else if (cnt != '0) begin
      cnt <= cnt - ONE;
    end
    rst_q  <= !line_i || (cnt != '0);
    rstn_q <= line_i && (cnt == '0);
  end

  assign rst_o   = rst_q;
  assign rst_n_o = rstn_q;

  AST_COMPLEMENT: assert property (@(posedge clk_i) disable iff (!warm)
    rst_q != rstn_q); // R2
  AST_HOLD_WHILE_LOW: assert property (@(posedge clk_i) disable iff (!warm)
    !line_i |=> rst_q); // R3
  AST_RELOAD_ON_LOW: assert property (@(posedge clk_i) disable iff (!warm)
    !line_i |=> (cnt == FULL)); // R5
  AST_STEP_DOWN: assert property (@(posedge clk_i) disable iff (!warm)
    (line_i && cnt != '0) |=> (cnt == $past(cnt) - ONE)); // R4
  AST_RELEASE_AT_ZERO: assert property (@(posedge clk_i) disable iff (!warm)
    $fell(rst_q) |-> ($past(cnt) == '0 && $past(line_i))); // R4
  AST_STAY_RELEASED: assert property (@(posedge clk_i) disable iff (!warm)
    (!rst_q && line_i) |=> !rst_q); // R6

endmodule

// File: rtl/rsg_por_stretch.sv
module rsg_por_stretch #(
  parameter int unsigned PULSE_CYCLES = rsg_pkg::RSG_DEFAULT_PULSE,
  parameter int unsigned SYNC_STAGES  = rsg_pkg::RSG_DEFAULT_SYNC
) (
  input  logic clk_i,
  input  logic pwr_ok_i,
  output logic rst_o,
  output logic rst_n_o
);

  logic line_sync;

  rsg_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .d_i   (pwr_ok_i),
    .q_o   (line_sync)
  );

  rsg_timer #(.PULSE_CYCLES(PULSE_CYCLES)) i_timer (
    .clk_i   (clk_i),
    .line_i  (line_sync),
    .rst_o   (rst_o),
    .rst_n_o (rst_n_o)
  );

endmodule

// File: tb/test_rsg_por_stretch.sv
module test_rsg_por_stretch;

  localparam int P = 12;
  localparam int S = 2;
  localparam int H = P + S + 1;

  logic clk    = 1'b0;
  logic pwr_ok = 1'b0;
  logic rst;
  logic rst_n;

  always #10 clk = ~clk;

  rsg_por_stretch #(.PULSE_CYCLES(P), .SYNC_STAGES(S)) i_rsg_por_stretch (
    .clk_i    (clk),
    .pwr_ok_i (pwr_ok),
    .rst_o    (rst),
    .rst_n_o  (rst_n)
  );

  // Line history: bit 0 = value sampled at the most recent edge.
  logic [H-1:0] hist = '0;
  always @(posedge clk) hist <= {hist[H-2:0], pwr_ok};

  int    checks = 0;
  int    fails  = 0;
  string tag    = "R1";
  bit    done   = 1'b0;

  task automatic judge(input string req);
    logic exp;
    exp = !(&hist[H-1:S]);
    checks++;
    if (rst !== exp) begin
      fails++;
      $display("FAIL %s: rst_o=%b expected %b at %0t", req, rst, exp, $time);
    end
    checks++;
    if (rst_n !== !exp) begin
      fails++;
      $display("FAIL R2: rst_n_o=%b expected %b at %0t", rst_n, !exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) judge(tag);

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1;
    judge("R1");                       // R1: reset state before any edge
    pwr_ok = 1'b1;
    wait_cyc(P + S);
    tag = "R4";                        // R4: first release after power-up
    wait_cyc(6);
    tag = "R6";                        // R6: stays released
    wait_cyc(10);
    for (int w = 1; w <= 20; w++) begin
      tag = "R3";                      // R3: held while low
      pwr_ok = 1'b0;
      wait_cyc(w);
      tag = "R7";                      // R7: repeated full width
      pwr_ok = 1'b1;
      wait_cyc(P + S + 4);
    end
    for (int k = 0; k <= P + S + 1; k++) begin
      pwr_ok = 1'b0;
      wait_cyc(2);
      pwr_ok = 1'b1;
      wait_cyc(k);
      tag = "R5";                      // R5: retrigger at every offset
      pwr_ok = 1'b0;
      wait_cyc((k % 3) + 1);
      pwr_ok = 1'b1;
      wait_cyc(P + S + 4);
      tag = "R6";
      wait_cyc(3);
    end
    finish_run();
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      finish_run();
    end
  end

endmodule